// File: doc/BRIEF.md
# Ternary Differential-Column Neuron

This block is a cycle-level digital model of a single binary-output neuron that reads a resistive crossbar in which each signed weight occupies two cells, one on a plus column and one on a minus column. Each cell is either low resistance (conducting strongly) or high resistance (conducting weakly). The block receives one crossbar row per handshake beat: a 0/1 row-drive bit and a two-bit weight code. It maps the code onto the two cell states and adds each driven row's cell contributions to a plus-column sum and a minus-column sum. After the beat flagged as last, it presents a +1/-1 activation from comparing the two sums.

Alongside the activation, the block reports the number of low-resistance cells in the weight set. This count stands in for crossbar read power, so weight sets quantized to two levels and to three levels can be compared. A mode input limits the legal codes to the two-level set. Codes that are not legal are flagged and stored as an all-high-resistance pair.

A result is held until the consumer accepts it. While a result is held the block accepts no new rows. Once the result is taken, the sums clear and the next vector can start on the following cycle.

Top module: `tern_pair_neuron`

## Requirements
- R1: An accepted row with weight code 2'b01 (+1) and drive bit 1 adds LRS_UNITS (default 100) to the plus sum and HRS_UNITS (default 1) to the minus sum.
- R2: An accepted row with weight code 2'b10 (-1) and drive bit 1 adds HRS_UNITS to the plus sum and LRS_UNITS to the minus sum.
- R3: In three-level mode (binMode = 0), code 2'b00 (weight 0) with drive bit 1 adds HRS_UNITS to both sums and contributes no low-resistance cell.
- R4: An accepted row whose drive bit is 0 leaves both sums unchanged, whatever its weight code.
- R5: outAct is 1 (+1) when outPlusSum is greater than outMinusSum, and 0 (-1) otherwise, including when the sums are equal.
- R6: Code 2'b11 sets outError for the vector and is stored as weight 0 (high resistance on both columns).
- R7: In two-level mode (binMode = 1), code 2'b00 sets outError and is stored as weight 0. Codes 2'b01 and 2'b10 stay legal.
- R8: inReady is high and outValid is low while rows are collected. The beat with inLast set moves the block to a held state on the same clock edge. In the held state outValid is high, inReady is low, and all outputs stay constant until outReady is high at a clock edge. That edge clears the sums, the count and the error flag, and rows are accepted again from the next cycle.
- R9: outLrsCount equals the number of low-resistance cells among all rows of the vector, counted whether or not each row is driven. A +1 or -1 weight adds one cell; weight 0 and flagged codes add none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| binMode | input | 1 | 1: only +1/-1 codes are legal; 0: weight 0 is also legal |
| inValid | input | 1 | A row beat is offered |
| inReady | output | 1 | The block accepts a row beat |
| inBit | input | 1 | Row-drive bit of the beat |
| inWeight | input | 2 | Weight code: 00 zero, 01 plus one, 10 minus one, 11 illegal |
| inLast | input | 1 | Marks the final row of a vector |
| outValid | output | 1 | A result is held |
| outReady | input | 1 | The consumer takes the held result |
| outAct | output | 1 | Activation: 1 means +1, 0 means -1 |
| outPlusSum | output | SUM_W (13) | Plus-column sum |
| outMinusSum | output | SUM_W (13) | Minus-column sum |
| outLrsCount | output | CNT_W (7) | Number of low-resistance cells in the vector |
| outError | output | 1 | At least one row of the vector carried an illegal code |

## Verification
Four behaviours are checked on every cycle by the assertions. Each +1, -1 and weight-0 row must move the two sums by exactly the per-cell units. An undriven row must leave the sums where they were. The held result must not move and must block further rows. Taking the result must zero the accumulators. Other behaviours can only be shown by the bench's scenarios, because they depend on whole vectors: the activation for a tie, the error flag in each mode, the cell count over undriven rows, and long mixed vectors at full depth.

// File: rtl/tern_pair_pkg.sv
package tern_pair_pkg;

  typedef enum logic [1:0] {
    W_ZERO = 2'b00,
    W_POS  = 2'b01,
    W_NEG  = 2'b10,
    W_BAD  = 2'b11
  } weightCode_t;

  typedef struct packed {
    logic accum;
    logic clear;
  } ctrlStrobe_t;

endpackage

// File: rtl/tern_cell_map.sv
module tern_cell_map (
  input  logic [1:0] code,
  input  logic       binMode,
  output logic       plusLow,
  output logic       minusLow,
  output logic       illegal
);
  import tern_pair_pkg::*;

  always_comb begin
    plusLow  = 1'b0;
    minusLow = 1'b0;
    illegal  = 1'b0;
    case (weightCode_t'(code))
      W_POS:  plusLow  = 1'b1;
      W_NEG:  minusLow = 1'b1;
      W_ZERO: illegal  = binMode;
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/tern_pair_ctrl.sv
module tern_pair_ctrl
  import tern_pair_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output ctrlStrobe_t strobe
);
  typedef enum logic {ST_COLLECT, ST_HOLD} state_t;
  state_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_COLLECT;
    end else begin
      case (state)
        ST_COLLECT: if (inValid && inLast) state <= ST_HOLD;
        default:    if (outReady) state <= ST_COLLECT;
      endcase
    end
  end

  always_comb begin
    inReady      = (state == ST_COLLECT);
    outValid     = (state == ST_HOLD);
    strobe.accum = (state == ST_COLLECT) && inValid;
    strobe.clear = (state == ST_HOLD) && outReady;
  end
endmodule

// File: rtl/tern_pair_dp.sv
module tern_pair_dp
  import tern_pair_pkg::*;
#(
  parameter int SUM_W     = 13,
  parameter int CNT_W     = 7,
  parameter int LRS_UNITS = 100,
  parameter int HRS_UNITS = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic             binMode,
  input  logic             inBit,
  input  logic [1:0]       inWeight,
  output logic [SUM_W-1:0] plusSum,
  output logic [SUM_W-1:0] minusSum,
  output logic [CNT_W-1:0] lrsCount,
  output logic             errSeen,
  output logic             act
);
  localparam logic [SUM_W-1:0] LOW_V  = SUM_W'(LRS_UNITS);
  localparam logic [SUM_W-1:0] HIGH_V = SUM_W'(HRS_UNITS);

  logic plusLow, minusLow, illegal;
  logic [SUM_W-1:0] plusAdd, minusAdd;
  logic [CNT_W-1:0] lowAdd;

  tern_cell_map u_map (
    .code    (inWeight),
    .binMode (binMode),
    .plusLow (plusLow),
    .minusLow(minusLow),
    .illegal (illegal)
  );

  always_comb begin
    plusAdd  = inBit ? (plusLow  ? LOW_V : HIGH_V) : '0;
    minusAdd = inBit ? (minusLow ? LOW_V : HIGH_V) : '0;
    lowAdd   = CNT_W'(plusLow) + CNT_W'(minusLow);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      plusSum  <= '0;
      minusSum <= '0;
      lrsCount <= '0;
      errSeen  <= 1'b0;
    end else if (strobe.accum) begin
      plusSum  <= plusSum + plusAdd;
      minusSum <= minusSum + minusAdd;
      lrsCount <= lrsCount + lowAdd;
      errSeen  <= errSeen | illegal;
    end
  end

  assign act = (plusSum > minusSum);
endmodule

// File: rtl/tern_pair_neuron.sv
module tern_pair_neuron
  import tern_pair_pkg::*;
#(
  parameter int MAX_ROWS  = 64,
  parameter int LRS_UNITS = 100,
  parameter int HRS_UNITS = 1,
  localparam int SUM_W    = $clog2(MAX_ROWS * LRS_UNITS + 1),
  localparam int CNT_W    = $clog2(MAX_ROWS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             binMode,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inBit,
  input  logic [1:0]       inWeight,
  input  logic             inLast,
  output logic             outValid,
  input  logic             outReady,
  output logic             outAct,
  output logic [SUM_W-1:0] outPlusSum,
  output logic [SUM_W-1:0] outMinusSum,
  output logic [CNT_W-1:0] outLrsCount,
  output logic             outError
);
  ctrlStrobe_t strobe;

  tern_pair_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  tern_pair_dp #(
    .SUM_W    (SUM_W),
    .CNT_W    (CNT_W),
    .LRS_UNITS(LRS_UNITS),
    .HRS_UNITS(HRS_UNITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .binMode (binMode),
    .inBit   (inBit),
    .inWeight(inWeight),
    .plusSum (outPlusSum),
    .minusSum(outMinusSum),
    .lrsCount(outLrsCount),
    .errSeen (outError),
    .act     (outAct)
  );
endmodule

// File: rtl/tern_pair_neuron_chk.sv
module tern_pair_neuron_chk #(
  parameter int SUM_W     = 13,
  parameter int CNT_W     = 7,
  parameter int LRS_UNITS = 100,
  parameter int HRS_UNITS = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             binMode,
  input logic             inValid,
  input logic             inReady,
  input logic             inBit,
  input logic [1:0]       inWeight,
  input logic             outValid,
  input logic             outReady,
  input logic [SUM_W-1:0] outPlusSum,
  input logic [SUM_W-1:0] outMinusSum,
  input logic [CNT_W-1:0] outLrsCount
);
  localparam logic [SUM_W-1:0] LOW_V  = SUM_W'(LRS_UNITS);
  localparam logic [SUM_W-1:0] HIGH_V = SUM_W'(HRS_UNITS);

  assert_pos_row_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inBit && inWeight == 2'b01) |=>
      (outPlusSum == $past(outPlusSum) + LOW_V) &&
      (outMinusSum == $past(outMinusSum) + HIGH_V));

  assert_neg_row_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inBit && inWeight == 2'b10) |=>
      (outPlusSum == $past(outPlusSum) + HIGH_V) &&
      (outMinusSum == $past(outMinusSum) + LOW_V));

  assert_zero_row_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inBit && inWeight == 2'b00 && !binMode) |=>
      (outPlusSum == $past(outPlusSum) + HIGH_V) &&
      (outMinusSum == $past(outMinusSum) + HIGH_V));

  assert_undriven_row_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !inBit) |=>
      $stable(outPlusSum) && $stable(outMinusSum));

  assert_hold_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && inReady));

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=>
      outValid && $stable(outPlusSum) && $stable(outMinusSum) && $stable(outLrsCount));

  assert_take_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=>
      !outValid && inReady && outPlusSum == '0 && outMinusSum == '0 && outLrsCount == '0);

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=>
      (outLrsCount - $past(outLrsCount)) <= CNT_W'(1));
endmodule

bind tern_pair_neuron tern_pair_neuron_chk #(
  .SUM_W    (SUM_W),
  .CNT_W    (CNT_W),
  .LRS_UNITS(LRS_UNITS),
  .HRS_UNITS(HRS_UNITS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .binMode    (binMode),
  .inValid    (inValid),
  .inReady    (inReady),
  .inBit      (inBit),
  .inWeight   (inWeight),
  .outValid   (outValid),
  .outReady   (outReady),
  .outPlusSum (outPlusSum),
  .outMinusSum(outMinusSum),
  .outLrsCount(outLrsCount)
);

// File: tb/tern_pair_neuron_test.sv
module tern_pair_neuron_test;
  localparam int ROWS  = 64;
  localparam int SUM_W = 13;
  localparam int CNT_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic binMode = 1'b0;
  logic inValid = 1'b0;
  logic inBit = 1'b0;
  logic [1:0] inWeight = 2'b00;
  logic inLast = 1'b0;
  logic outReady = 1'b0;
  logic inReady, outValid, outAct, outError;
  logic [SUM_W-1:0] outPlusSum, outMinusSum;
  logic [CNT_W-1:0] outLrsCount;

  int checks = 0;
  int errors = 0;
  int vecBits [ROWS];
  int vecW [ROWS];

  always #5 clk = ~clk;

  tern_pair_neuron uut (
    .clk(clk), .rstN(rstN), .binMode(binMode),
    .inValid(inValid), .inReady(inReady), .inBit(inBit),
    .inWeight(inWeight), .inLast(inLast),
    .outValid(outValid), .outReady(outReady), .outAct(outAct),
    .outPlusSum(outPlusSum), .outMinusSum(outMinusSum),
    .outLrsCount(outLrsCount), .outError(outError)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runVector(input int n, input int mode, input string tag);
    int ep = 0, em = 0, el = 0, ee = 0;
    for (int i = 0; i < n; i++) begin
      int pl, ml;
      pl = (vecW[i] == 1) ? 1 : 0;
      ml = (vecW[i] == 2) ? 1 : 0;
      if (vecW[i] == 3 || (mode == 1 && vecW[i] == 0)) ee = 1;
      if (vecBits[i] != 0) begin
        ep += pl ? 100 : 1;
        em += ml ? 100 : 1;
      end
      el += pl + ml;
    end
    binMode = mode[0];
    for (int i = 0; i < n; i++) begin
      inValid  = 1'b1;
      inBit    = vecBits[i][0];
      inWeight = vecW[i][1:0];
      inLast   = (i == n - 1);
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    chk({tag, " R8 outValid"}, int'(outValid), 1);
    chk({tag, " R8 inReady"}, int'(inReady), 0);
    chk({tag, " plus sum"}, int'(outPlusSum), ep);
    chk({tag, " minus sum"}, int'(outMinusSum), em);
    chk({tag, " R5 act"}, int'(outAct), (ep > em) ? 1 : 0);
    chk({tag, " R9 lrs count"}, int'(outLrsCount), el);
    chk({tag, " error"}, int'(outError), ee);
    repeat (2) @(negedge clk);
    chk({tag, " R8 held valid"}, int'(outValid), 1);
    chk({tag, " R8 held plus"}, int'(outPlusSum), ep);
    chk({tag, " R8 held count"}, int'(outLrsCount), el);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    chk({tag, " R8 cleared valid"}, int'(outValid), 0);
    chk({tag, " R8 ready again"}, int'(inReady), 1);
    chk({tag, " R8 cleared sum"}, int'(outPlusSum) + int'(outMinusSum) + int'(outLrsCount), 0);
    chk({tag, " R8 cleared error"}, int'(outError), 0);
  endtask

  task automatic fill(input int n, input int bitv, input int w);
    for (int i = 0; i < n; i++) begin
      vecBits[i] = bitv;
      vecW[i] = w;
    end
  endtask

  task automatic testReset;
    chk("reset R8 outValid", int'(outValid), 0);
    chk("reset R8 inReady", int'(inReady), 1);
    chk("reset sums", int'(outPlusSum) + int'(outMinusSum), 0);
    chk("reset R9 count", int'(outLrsCount), 0);
  endtask

  task automatic testPositive;
    fill(4, 1, 1);
    runVector(4, 0, "R1 all plus");
  endtask

  task automatic testNegative;
    fill(4, 1, 2);
    runVector(4, 1, "R2 all minus binary");
  endtask

  task automatic testZeroTie;
    fill(3, 1, 0);
    runVector(3, 0, "R3 zeros tie R5");
  endtask

  task automatic testUndriven;
    fill(4, 0, 1);
    runVector(4, 0, "R4 undriven plus R9");
    fill(3, 0, 2);
    vecBits[1] = 1;
    vecW[1] = 1;
    runVector(3, 0, "R4 one driven");
  endtask

  task automatic testIllegal;
    fill(3, 1, 1);
    vecW[1] = 3;
    runVector(3, 0, "R6 code 11");
  endtask

  task automatic testBinaryMode;
    fill(3, 1, 2);
    vecW[2] = 0;
    runVector(3, 1, "R7 zero in binary");
    fill(2, 1, 1);
    vecW[1] = 2;
    runVector(2, 1, "R7 legal binary tie R5");
  endtask

  task automatic testLongMixed;
    for (int i = 0; i < ROWS; i++) begin
      vecBits[i] = ((i % 3) != 0) ? 1 : 0;
      vecW[i] = (i * 7 + 1) % 3;
    end
    runVector(ROWS, 0, "R9 long mixed R1 R2 R3");
    runVector(1, 0, "R8 single row");
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPositive();
    testNegative();
    testZeroTie();
    testUndriven();
    testIllegal();
    testBinaryMode();
    testLongMixed();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule